// File: doc/BRIEF.md
# Pair-Aware Run-Length Sample Encoder

This block is the compression stage between a logic analyzer's sampler and its capture memory. Each accepted 32-bit sample word either extends the current run or closes it. When a run closes, the block writes the run's value as a sample word with bit 31 clear. If the run held more than one word, it then writes a count word that has bit 31 set and the run length in bits 30..0. Because bit 31 is the flag, sample words carry 31 channels in the normal packing, and channel 31 is always stored as 0.

A mode input selects the double-rate packing. In that packing each word holds two 16-bit samples: the earlier one in bits 15..0 and the later one in bits 31..16. Runs are then runs of identical sample pairs, and the count gives the number of pairs. In this mode both halves are cut to 15 channels, because bits 15 and 31 are both cleared before comparison and storage. As a result a decoder that splits words into 16-bit samples sees the same channel set in every sample.

When compression is disabled, words go through unchanged after one clock. A flush pulse at the end of a capture writes out the run still in progress. The counter saturates at `RUN_MAX`: the full run is written out, and counting starts again on the same value.

Top module: `rle_pair_encoder`

## Requirements
- R1: After reset `out_valid` is low and stays low until a word or count is produced.
- R2: With `rle_en` low, every `in_valid` word appears unchanged, bit 31 included, on `out_data` with `out_valid` high one clock later. Words may arrive back to back.
- R3: With `rle_en` high and `demux_mode` low, words are compared after bit 31 is cleared. When a differing word arrives, the run value (bit 31 = 0) is output one clock later.
- R4: A closed run of length N >= 2 is followed, in the very next clock, by a count word with bit 31 = 1 and bits 30..0 = N. A run of length 1 produces no count word.
- R5: With `demux_mode` high, runs are formed on whole 32-bit pair words, and the count gives the number of repeated pairs.
- R6: With `demux_mode` high, bits 31 and 15 are both cleared before comparison and storage. Pair words that differ only in those bits extend the same run.
- R7: When a run reaches `RUN_MAX` and another equal word arrives, the run is output as its value followed by a count of `RUN_MAX`. A new run of length 1 with the same value then begins.
- R8: A `flush` pulse outputs the run in progress (value, plus a count if its length is 2 or more) and leaves the encoder empty. A flush with no run in progress produces no output.
- R9: With `rle_en` high, a cycle with `in_valid` or `flush` is always followed by a cycle with neither, and `in_valid` and `flush` never coincide. Under this rule no output is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rle_en | input | 1 | 1 = run-length compression, 0 = one-clock pass-through |
| demux_mode | input | 1 | 1 = word holds two 16-bit samples (15+15 channels) |
| in_valid | input | 1 | `in_data` holds a sample word this cycle |
| in_data | input | 32 | Sample word |
| flush | input | 1 | End of capture: write out the pending run |
| out_valid | output | 1 | `out_data` is to be written to capture memory |
| out_data | output | 32 | Sample word (bit 31 = 0) or count word (bit 31 = 1) |

## Verification
The bench targets several corner cases:
- Words that differ only in a masked bit must merge into one run. A design that compared unmasked words would split them into two runs with different stored values.
- In pair mode, a cleared bit 15 must be visible in the stored value. An encoder unaware of the pair packing would keep bit 15 and lose only the upper sample's top channel.
- A run of exactly `RUN_MAX`, and one that goes past it, exercise saturation. An off-by-one counter would report `RUN_MAX+1` or wrap to a small count.
- Flushing with nothing pending, and runs of one word, must produce no stray count words.

// File: rtl/rle_pair_encoder.sv
module rle_pair_encoder #(
  parameter int RUN_MAX = 32'h7FFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rle_en,
  input  logic        demux_mode,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        flush,
  output logic        out_valid,
  output logic [31:0] out_data
);
  localparam int CW = 31;
  localparam logic [31:0] KEEP_WIDE = 32'h7FFF_FFFF;
  localparam logic [31:0] KEEP_PAIR = 32'h7FFF_7FFF;
  localparam logic [CW-1:0] LEN_MAX = CW'(RUN_MAX);
  localparam logic [CW-1:0] LEN_ONE = CW'(1);

  logic [31:0]   run_val;
  logic [CW-1:0] run_len;
  logic          have_run;
  logic          pend_v;
  logic [CW-1:0] pend_len;

  wire [31:0] keep   = demux_mode ? KEEP_PAIR : KEEP_WIDE;
  wire [31:0] in_m   = in_data & keep;
  wire        take   = rle_en && in_valid;
  wire        at_max = run_len == LEN_MAX;
  wire        new_run = !have_run || in_m != run_val || at_max;
  wire        close_run = have_run &&
                          ((take && (in_m != run_val || at_max)) ||
                           (rle_en && flush && !in_valid));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      run_val   <= '0;
      run_len   <= '0;
      have_run  <= 1'b0;
      pend_v    <= 1'b0;
      pend_len  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!rle_en) begin
        out_valid <= in_valid;
        out_data  <= in_data;
      end else if (close_run) begin
        out_valid <= 1'b1;
        out_data  <= run_val;
      end else if (pend_v) begin
        out_valid <= 1'b1;
        out_data  <= {1'b1, pend_len};
      end

      if (close_run) begin
        pend_v   <= run_len != LEN_ONE;
        pend_len <= run_len;
      end else begin
        pend_v   <= 1'b0;
      end

      if (take) begin
        have_run <= 1'b1;
        if (new_run) begin
          run_val <= in_m;
          run_len <= LEN_ONE;
        end else begin
          run_len <= run_len + LEN_ONE;
        end
      end else if (rle_en && flush) begin
        have_run <= 1'b0;
      end
    end
  end

  assert_input_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rle_en && (in_valid || flush)) |=> !(in_valid || flush));

  assert_no_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(close_run && pend_v));

  assert_pass_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rle_en && in_valid) |=> (out_valid && out_data == $past(in_data)));

  assert_count_follows_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rle_en && $past(rle_en) && out_valid && out_data[31]) |->
      ($past(out_valid) && !$past(out_data[31])));

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rle_en && out_valid && out_data[31]) |->
      (out_data[30:0] >= 31'd2 && out_data[30:0] <= LEN_MAX));

  assert_pair_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rle_en && $past(rle_en) && demux_mode && $past(demux_mode) &&
     out_valid && !out_data[31]) |-> !out_data[15]);
endmodule

// File: tb/rle_pair_encoder_test.sv
module rle_pair_encoder_test;
  localparam int RMAX = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rle_en = 1'b0;
  logic demux_mode = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic flush = 1'b0;
  logic out_valid;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  rle_pair_encoder #(.RUN_MAX(RMAX)) uut (
    .clk(clk), .rst_n(rst_n), .rle_en(rle_en), .demux_mode(demux_mode),
    .in_valid(in_valid), .in_data(in_data), .flush(flush),
    .out_valid(out_valid), .out_data(out_data));

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";

  logic [31:0] m_val;
  int m_len = 0;
  bit m_have = 0;

  task automatic expect_word(input logic [31:0] w);
    exp_q.push_back(w);
    tag_q.push_back(cur_tag);
  endtask

  task automatic close_model();
    expect_word(m_val);
    if (m_len > 1) expect_word({1'b1, 31'(m_len)});
  endtask

  task automatic send(input logic [31:0] w);
    logic [31:0] mk;
    mk = w & (demux_mode ? 32'h7FFF_7FFF : 32'h7FFF_FFFF);
    if (!rle_en) expect_word(w);
    else if (!m_have) begin m_have = 1; m_val = mk; m_len = 1; end
    else if (mk != m_val || m_len == RMAX) begin
      close_model(); m_val = mk; m_len = 1;
    end else m_len++;
    @(posedge clk) #1;
    in_valid = 1'b1; in_data = w;
    @(posedge clk) #1;
    in_valid = 1'b0;
    if (rle_en) @(posedge clk) #1;
  endtask

  task automatic send_flush();
    if (m_have) close_model();
    m_have = 0;
    @(posedge clk) #1;
    flush = 1'b1;
    @(posedge clk) #1;
    flush = 1'b0;
    @(posedge clk) #1;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected output %h, expected none", cur_tag, out_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_data !== e) begin
          errors++;
          $display("FAIL %s: out_data %h, expected %h", t, out_data, e);
        end
      end
    end
  end

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid %b during reset, expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(posedge clk) #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid %b after reset, expected 0", out_valid);
    end

    // R2: pass-through, including back-to-back words
    cur_tag = "R2";
    send(32'hFFFF_FFFF);
    send(32'h8000_0001);
    expect_word(32'h1234_5678); expect_word(32'hDEAD_BEEF);
    @(posedge clk) #1; in_valid = 1'b1; in_data = 32'h1234_5678;
    @(posedge clk) #1; in_data = 32'hDEAD_BEEF;
    @(posedge clk) #1; in_valid = 1'b0;
    settle();

    // R3 / R4: normal packing, masked bit 31 merges
    rle_en = 1'b1;
    cur_tag = "R3";
    send(32'h8000_0007); send(32'h0000_0007); send(32'h8000_0007);
    cur_tag = "R4";
    send(32'h0000_00B0);
    send(32'h0000_00C0); send(32'h0000_00C0);
    send(32'h0000_00D0);
    send_flush();
    settle();

    // R7: saturation with a run past RUN_MAX
    cur_tag = "R7";
    for (int i = 0; i < RMAX + 2; i++) send(32'h0000_0AAA);
    send_flush();
    cur_tag = "R7";
    for (int i = 0; i < RMAX; i++) send(32'h0000_0BBB);
    send_flush();
    settle();

    // R8: flush with nothing pending gives nothing
    cur_tag = "R8";
    send_flush();
    settle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: %0d outputs missing, expected 0", exp_q.size());
    end

    // R5 / R6: pair packing
    demux_mode = 1'b1;
    cur_tag = "R5";
    for (int i = 0; i < 3; i++) send(32'h5100_5000);
    cur_tag = "R6";
    send(32'h5100_8000); send(32'hD100_0000);
    send(32'hFFFF_FFFF);
    send(32'h0001_0001);
    send_flush();
    settle();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d outputs missing, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule